// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block serves the transmit side of a network controller. It walks a ring of two-word descriptors held in system memory, reading each one through a simple word-wide memory port. For every descriptor it fetches the buffer pointer and the length. It then streams the buffer contents, one byte per beat, to a valid/ready frame output. When a buffer has been consumed, the engine writes the descriptor's control word back with the ownership bit set, so that software can reclaim the slot.

Software loads the ring base and fills descriptors with the ownership bit clear. A start pulse makes the engine work from its current descriptor pointer. It stops when it meets a descriptor that software still owns, or at the first frame boundary after a halt pulse. A later start resumes at the descriptor where it stopped. The stream output follows the usual back-pressure rule: once `m_tvalid_o` is high, data, last and error flags hold steady until `m_tready_i` is seen high on a clock edge. Nothing is dropped, and the engine never withdraws a beat.

Top module: `txd_dma`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o` and `m_tvalid_o` are low.
- R2: Descriptor n sits at pointer P. Its buffer byte address is the word at P, and its control word is the word at P+4. Control bits 10:0 give the buffer length in bytes. The buffer bytes go out in address order, starting at any byte alignment. Byte k of a memory word is taken from bits 8k+7:8k.
- R3: `m_tlast_o` is high only on the final byte of a buffer whose control bit 15 is set. A buffer with bit 15 clear continues the same frame into the next descriptor.
- R4: If control bit 30 is set, the next descriptor is read from the ring base. Otherwise the next descriptor is at P+8.
- R5: Reading a control word with bit 31 set between frames stops the engine: `busy_o` falls and no beat is sent. The pointer stays on that descriptor, and a later start re-reads it.
- R6: When a buffer has been consumed, its control word is written back with bit 31 set and bits 29:27 cleared. All other bits are unchanged.
- R7: If a control word with bit 31 set is read inside a frame, the engine sends one beat with data 0x00, `m_tlast_o`=1 and `m_tuser_o`=1. It then writes that control word back with bit 27 added and stops.
- R8: A zero-length buffer sends no data byte. If it carries bit 15, a single terminating beat is sent with data 0x00, `m_tlast_o`=1 and `m_tuser_o`=0.
- R9: After a halt pulse, the frame in progress is finished and written back, and the engine then stops. Later descriptors are left untouched until the next start.
- R10: A write of the queue base (`qbase_we_i`) loads the base and moves the descriptor pointer to it.
- R11: While `m_tvalid_o` is high and `m_tready_i` is low, `m_tvalid_o`, `m_tdata_o`, `m_tlast_o` and `m_tuser_o` hold their values into the next cycle.
- R12: A memory request is held, with the same address and direction, until `mem_ack_i`. Every memory address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: begin processing at the current pointer |
| halt_i | input | 1 | Pulse: stop at the next frame boundary |
| qbase_we_i | input | 1 | Load ring base and pointer |
| qbase_i | input | AW | Ring base byte address |
| busy_o | output | 1 | High while the engine is working |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | 8 | Stream byte |
| m_tlast_o | output | 1 | Final beat of a frame |
| m_tuser_o | output | 1 | Frame aborted by exhausted descriptors |

## Verification
The bench builds the engine with a 10-bit address width. At that width the whole address space fits in a 256-word model memory, so every descriptor write-back can be read back and compared. The model memory acknowledges after 0 to 2 wait cycles, and the sink drops ready once every five cycles. Together these exercise held requests and stalled beats across word crossings, including an unaligned buffer start. Because the ring is small, wrap, stop and restart, exhaustion inside a frame, zero-length buffers and a halt in mid-frame all fit in a short run.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int LEN_W    = 11;
  localparam int B_LAST   = 15;
  localparam int B_EXH    = 27;
  localparam int B_UNDR   = 28;
  localparam int B_RETRY  = 29;
  localparam int B_WRAP   = 30;
  localparam int B_USED   = 31;

  localparam logic [31:0] STAT_MASK =
    (32'd1 << B_EXH) | (32'd1 << B_UNDR) | (32'd1 << B_RETRY);

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTRL,
    S_RD_ADDR,
    S_RD_DATA,
    S_SEND,
    S_TERM,
    S_WB,
    S_EXH_WB
  } txd_state_e;
endpackage

// File: rtl/txd_ptr.sv
module txd_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(8);

  logic [AW-1:0] base_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (load_i) begin
      base_q <= {base_i[AW-1:2], 2'b00};
      ptr_q  <= {base_i[AW-1:2], 2'b00};
    end else if (adv_i) begin
      ptr_q <= wrap_i ? base_q : ptr_q + STEP;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/txd_cursor.sv
module txd_cursor #(
  parameter int AW = 32,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          final_o,
  output logic          word_end_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      rem_q  <= rem_q - LW'(1);
    end
  end

  assign addr_o     = addr_q;
  assign final_o    = (rem_q == LW'(1));
  assign word_end_o = (addr_q[1:0] == 2'b11);
endmodule

// File: rtl/txd_lane.sv
module txd_lane #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0]       word_i,
  input  logic [$clog2(LANES)-1:0] sel_i,
  output logic [7:0]               byte_o
);
  logic [7:0] lane [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = word_i[8*i +: 8];
  end

  assign byte_o = lane[sel_i];
endmodule

// File: rtl/txd_dma.sv
module txd_dma
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          halt_i,
  input  logic          qbase_we_i,
  input  logic [AW-1:0] qbase_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          m_tvalid_o,
  input  logic          m_tready_i,
  output logic [7:0]    m_tdata_o,
  output logic          m_tlast_o,
  output logic          m_tuser_o
);
  localparam logic [AW-1:0] CTRL_OFS = AW'(4);

  txd_state_e    state_q, state_d;
  logic [31:0]   ctrl_q;
  logic [31:0]   word_q;
  logic          in_frame_q;
  logic          err_q;
  logic          halt_pend_q;

  logic [AW-1:0] ptr;
  logic [AW-1:0] cur_addr;
  logic          cur_final;
  logic          cur_word_end;
  logic [7:0]    lane_byte;

  logic          ack;
  logic          beat_go;
  logic          ptr_adv;
  logic          cur_load;
  logic          cur_step;
  logic          halting;
  logic [LEN_W-1:0] ctrl_len;

  assign ack      = mem_req_o && mem_ack_i;
  assign beat_go  = m_tvalid_o && m_tready_i;
  assign ctrl_len = ctrl_q[LEN_W-1:0];
  assign halting  = halt_pend_q || halt_i;
  assign ptr_adv  = (state_q == S_WB) && mem_ack_i;
  assign cur_load = (state_q == S_RD_ADDR) && mem_ack_i;
  assign cur_step = (state_q == S_SEND) && m_tready_i;

  txd_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (qbase_we_i),
    .base_i (qbase_i),
    .adv_i  (ptr_adv),
    .wrap_i (ctrl_q[B_WRAP]),
    .ptr_o  (ptr)
  );

  txd_cursor #(.AW(AW), .LW(LEN_W)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cur_load),
    .addr_i     (mem_rdata_i[AW-1:0]),
    .len_i      (ctrl_len),
    .step_i     (cur_step),
    .addr_o     (cur_addr),
    .final_o    (cur_final),
    .word_end_o (cur_word_end)
  );

  txd_lane #(.LANES(4)) u_lane (
    .word_i (word_q),
    .sel_i  (cur_addr[1:0]),
    .byte_o (lane_byte)
  );

  // next-state decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_RD_CTRL;
      S_RD_CTRL: if (mem_ack_i) begin
        if (mem_rdata_i[B_USED]) state_d = in_frame_q ? S_TERM : S_IDLE;
        else                     state_d = S_RD_ADDR;
      end
      S_RD_ADDR: if (mem_ack_i) begin
        if (ctrl_len == '0) state_d = ctrl_q[B_LAST] ? S_TERM : S_WB;
        else                state_d = S_RD_DATA;
      end
      S_RD_DATA: if (mem_ack_i) state_d = S_SEND;
      S_SEND:    if (m_tready_i) begin
        if (cur_final)         state_d = S_WB;
        else if (cur_word_end) state_d = S_RD_DATA;
      end
      S_TERM:    if (m_tready_i) state_d = err_q ? S_EXH_WB : S_WB;
      S_WB:      if (mem_ack_i) state_d = (ctrl_q[B_LAST] && halting) ? S_IDLE : S_RD_CTRL;
      S_EXH_WB:  if (mem_ack_i) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      ctrl_q      <= '0;
      word_q      <= '0;
      in_frame_q  <= 1'b0;
      err_q       <= 1'b0;
      halt_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == S_RD_CTRL) && mem_ack_i) begin
        ctrl_q <= mem_rdata_i;
        err_q  <= mem_rdata_i[B_USED] && in_frame_q;
      end else if ((state_q == S_RD_ADDR) && mem_ack_i) begin
        err_q <= 1'b0;
      end
      if ((state_q == S_RD_DATA) && mem_ack_i) word_q <= mem_rdata_i;
      if (ptr_adv) in_frame_q <= !ctrl_q[B_LAST];
      else if ((state_q == S_EXH_WB) && mem_ack_i) in_frame_q <= 1'b0;
      if (state_d == S_IDLE)                   halt_pend_q <= 1'b0;
      else if (halt_i && state_q != S_IDLE)    halt_pend_q <= 1'b1;
    end
  end

  // memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr + CTRL_OFS;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_CTRL: mem_req_o = 1'b1;
      S_RD_ADDR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr;
      end
      S_RD_DATA: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {cur_addr[AW-1:2], 2'b00};
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = (ctrl_q & ~STAT_MASK) | (32'd1 << B_USED);
      end
      S_EXH_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = ctrl_q | (32'd1 << B_EXH);
      end
      default: ;
    endcase
  end

  // stream port
  always_comb begin
    m_tvalid_o = 1'b0;
    m_tdata_o  = 8'h00;
    m_tlast_o  = 1'b0;
    m_tuser_o  = 1'b0;
    if (state_q == S_SEND) begin
      m_tvalid_o = 1'b1;
      m_tdata_o  = lane_byte;
      m_tlast_o  = ctrl_q[B_LAST] && cur_final;
    end else if (state_q == S_TERM) begin
      m_tvalid_o = 1'b1;
      m_tlast_o  = 1'b1;
      m_tuser_o  = err_q;
    end
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/txd_dma_chk.sv
module txd_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          m_tvalid_o,
  input logic          m_tready_i,
  input logic [7:0]    m_tdata_o,
  input logic          m_tlast_o,
  input logic          m_tuser_o
);
  // R12: request held steady until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R12: word-aligned addressing
  p_addr_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R11: stalled beat is held
  p_axis_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid_o && !m_tready_i) |=>
      (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o) && $stable(m_tuser_o)));

  // R7: an aborted frame ends on a zero terminating beat
  p_abort_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid_o && m_tuser_o) |-> (m_tlast_o && m_tdata_o == 8'h00));

  // R6: every write-back hands ownership back
  p_wb_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[31]);

  // R7: no memory access and stream beat at once
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && m_tvalid_o));
endmodule

bind txd_dma txd_dma_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .m_tvalid_o  (m_tvalid_o),
  .m_tready_i  (m_tready_i),
  .m_tdata_o   (m_tdata_o),
  .m_tlast_o   (m_tlast_o),
  .m_tuser_o   (m_tuser_o)
);

// File: tb/tb_txd_dma.sv
module tb_txd_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          halt_i = 1'b0;
  logic          qbase_we_i = 1'b0;
  logic [AW-1:0] qbase_i = '0;
  logic          busy_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic          mem_ack_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic          m_tvalid_o;
  logic          m_tready_i = 1'b0;
  logic [7:0]    m_tdata_o;
  logic          m_tlast_o, m_tuser_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] mem [256];
  logic [9:0]  exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_dma #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_i(halt_i),
    .qbase_we_i(qbase_we_i), .qbase_i(qbase_i), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i), .m_tdata_o(m_tdata_o),
    .m_tlast_o(m_tlast_o), .m_tuser_o(m_tuser_o)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 5 + 17) & 255);
  endfunction

  // memory responder: 0..2 wait cycles
  initial begin
    int wcnt = 0;
    int opn = 0;
    forever begin
      @(posedge clk);
      if (mem_ack_i) mem_ack_i <= 1'b0;
      else if (mem_req_o) begin
        if (wcnt >= opn % 3) begin
          mem_ack_i   <= 1'b1;
          mem_rdata_i <= mem[mem_addr_o[9:2]];
          if (mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
          wcnt = 0;
          opn++;
        end else wcnt++;
      end
    end
  end

  // sink ready pattern
  initial begin
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      c++;
      m_tready_i = (c % 5) != 3;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (m_tvalid_o && m_tready_i) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2: unexpected beat data=%h last=%b user=%b expected none",
                   m_tdata_o, m_tlast_o, m_tuser_o);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          if ({m_tuser_o, m_tlast_o, m_tdata_o} !== e) begin
            fails++;
            $display("FAIL R2/R3/R7/R8: beat {user,last,data} actual=%h expected=%h",
                     {m_tuser_o, m_tlast_o, m_tdata_o}, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(int p, int addr, logic [31:0] ctrl);
    mem[p >> 2]       = 32'(addr);
    mem[(p >> 2) + 1] = ctrl;
  endtask

  task automatic expect_buf(int addr, int len, bit last);
    for (int i = 0; i < len; i++)
      exp_q.push_back({1'b0, last && (i == len - 1), pat(addr + i)});
  endtask

  task automatic expect_term(bit err);
    exp_q.push_back({err, 1'b1, 8'h00});
  endtask

  task automatic set_base(int b);
    @(negedge clk);
    qbase_i = AW'(b);
    qbase_we_i = 1'b1;
    @(negedge clk);
    qbase_we_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(string req);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
    check(req, 32'(exp_q.size()), 32'd0);
    check(req, {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    for (int w = 128; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    for (int w = 0; w < 128; w++) mem[w] = 32'h8000_0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 busy", {31'd0, busy_o}, 0);
    check("R1 req", {31'd0, mem_req_o}, 0);
    check("R1 tvalid", {31'd0, m_tvalid_o}, 0);

    // R2 R3 R6: two-buffer frame, unaligned second buffer, status bits cleared
    put_desc(32'h100, 32'h200, 32'h3801_0005);
    put_desc(32'h108, 32'h243, 32'h0000_8006);
    put_desc(32'h110, 0, 32'h8000_0000);
    set_base(32'h100);
    expect_buf(32'h200, 5, 0);
    expect_buf(32'h243, 6, 1);
    pulse_start();
    wait_idle("R5 stop on owned descriptor");
    check("R6 writeback d0", mem[32'h104 >> 2], 32'h8001_0005);
    check("R6 writeback d1", mem[32'h10C >> 2], 32'h8000_8006);

    // R4 R5: restart at stopped descriptor, wrap back to base
    put_desc(32'h110, 32'h280, 32'h4000_8003);
    put_desc(32'h100, 32'h2A0, 32'h0000_8002);
    put_desc(32'h108, 0, 32'h8000_0000);
    expect_buf(32'h280, 3, 1);
    expect_buf(32'h2A0, 2, 1);
    pulse_start();
    wait_idle("R4 wrap ring");
    check("R4 wrap desc writeback", mem[32'h114 >> 2], 32'hC000_8003);
    check("R4 base desc writeback", mem[32'h104 >> 2], 32'h8000_8002);

    // R10 R7: new base, owned descriptor inside a frame
    put_desc(32'h180, 32'h2C0, 32'h0000_0004);
    put_desc(32'h188, 0, 32'h8000_0040);
    set_base(32'h180);
    expect_buf(32'h2C0, 4, 0);
    expect_term(1);
    pulse_start();
    wait_idle("R7 exhausted frame");
    check("R10 first desc from new base", mem[32'h184 >> 2], 32'h8000_0004);
    check("R7 exhausted flag", mem[32'h18C >> 2], 32'h8800_0040);

    // R8: zero-length buffers
    put_desc(32'h1C0, 32'h2F0, 32'h0000_0000);
    put_desc(32'h1C8, 32'h2E1, 32'h0000_8002);
    put_desc(32'h1D0, 32'h2F0, 32'h0000_8000);
    put_desc(32'h1D8, 0, 32'h8000_0000);
    set_base(32'h1C0);
    expect_buf(32'h2E1, 2, 1);
    expect_term(0);
    pulse_start();
    wait_idle("R8 zero length");
    check("R8 empty desc writeback", mem[32'h1C4 >> 2], 32'h8000_0000);
    check("R8 empty last writeback", mem[32'h1D4 >> 2], 32'h8000_8000);

    // R9: halt mid-frame
    put_desc(32'h100, 32'h300, 32'h0000_8014);
    put_desc(32'h108, 32'h340, 32'h0000_8003);
    put_desc(32'h110, 0, 32'h8000_0000);
    set_base(32'h100);
    expect_buf(32'h300, 20, 1);
    pulse_start();
    repeat (3) @(negedge clk);
    halt_i = 1'b1;
    @(negedge clk);
    halt_i = 1'b0;
    wait_idle("R9 halt finishes frame");
    check("R9 next desc untouched", mem[32'h10C >> 2], 32'h0000_8003);
    check("R9 halted frame writeback", mem[32'h104 >> 2], 32'h8000_8014);
    expect_buf(32'h340, 3, 1);
    pulse_start();
    wait_idle("R9 resume after halt");
    check("R9 resumed writeback", mem[32'h10C >> 2], 32'h8000_8003);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule